// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Control

This block holds the data-hazard decisions of a five-stage in-order pipeline in which the register file is read only in decode and written only in write-back. For each of the two ALU operands of the instruction now in execute, it picks where the operand comes from. The choices are the value read from the register file, the ALU result held in the execute/memory pipeline register, or the write-back value held in the memory/write-back pipeline register.

The block also watches the instruction in decode. If the instruction in execute is a load whose destination is a source of the decode instruction, the block raises a hold for the program counter and the fetch/decode register. It also raises a bubble request so that the decode/execute register receives all-zero controls for one cycle. Older instructions keep moving, so the load reaches memory and its data is then forwarded from the memory/write-back register.

The block is purely combinational and has no valid/ready interface. It carries no data, only register numbers and control bits. Its outputs are plain control pins that the pipeline registers and operand muxes consume in the same cycle.

Top module: `hzd_unit`

## Requirements
- R1: An execute source that equals `mem_rd`, with `mem_rd` nonzero, `mem_regwrite` high and `mem_memread` low, gets select 2'b10 (execute/memory ALU result).
- R2: An execute source that equals `wb_rd`, with `wb_rd` nonzero and `wb_regwrite` high, and that does not meet R1, gets select 2'b01 (memory/write-back value). This covers a load two instructions ahead.
- R3: When an execute source meets both the R1 and the R2 conditions, the select is 2'b10.
- R4: Register 0 is never forwarded and never causes a stall.
- R5: A stage whose write-enable is low is never a forwarding source.
- R6: A load in the memory stage (`mem_memread` high) is never taken as an execute/memory source. The select then falls to R2 or to 2'b00.
- R7: When `ex_memread` is high and `ex_rd` is nonzero and equals `id_rs1` or `id_rs2`, both `pc_ifid_hold` and `idex_bubble` are 1.
- R8: With `ex_memread` low there is no stall, whatever the register numbers are. Back-to-back ALU dependencies are served by forwarding alone.
- R9: An execute source that matches no qualifying stage gets select 2'b00 (register file). This includes an instruction three behind a producer, which reads the value already written.
- R10: `fwd_a` follows `ex_rs1` only and `fwd_b` follows `ex_rs2` only. Each is decided independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_W | First source register number in decode |
| id_rs2 | input | REG_W | Second source register number in decode |
| ex_rs1 | input | REG_W | First source register number in execute |
| ex_rs2 | input | REG_W | Second source register number in execute |
| ex_rd | input | REG_W | Destination register number in execute |
| ex_memread | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_W | Destination register number in memory stage |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_W | Destination register number in write-back |
| wb_regwrite | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/write-back |
| fwd_b | output | 2 | Operand B source, same encoding |
| pc_ifid_hold | output | 1 | Hold program counter and fetch/decode register |
| idex_bubble | output | 1 | Load all-zero controls into decode/execute register |

## Verification
The bench builds the block with its default REG_W of 5, so register 0 and a full-width register number such as 31 are both in range. Random register numbers are drawn from a narrow window of 0 to 3. This makes matches between stages frequent, and it makes cases where both stages match the same source and register-0 collisions common. Directed cases add load-then-use, a load two ahead, a load three ahead, and top-numbered registers.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/hzd_reg_match.sv
module hzd_reg_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] a,
  input  logic [REG_W-1:0] b,
  input  logic             en,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;
  always_comb hit = en && (a == b) && (b != ZERO_REG);
endmodule

// File: rtl/hzd_fwd_select.sv
module hzd_fwd_select
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_regwrite,
  output opnd_src_e        sel
);
  logic mem_hit, wb_hit;

  hzd_reg_match #(.REG_W(REG_W)) u_mem (
    .a(src), .b(mem_rd), .en(mem_regwrite && !mem_memread), .hit(mem_hit));
  hzd_reg_match #(.REG_W(REG_W)) u_wb (
    .a(src), .b(wb_rd), .en(wb_regwrite), .hit(wb_hit));

  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/hzd_loaduse_detect.sv
module hzd_loaduse_detect #(
  parameter int REG_W = 5,
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0][REG_W-1:0] id_src,
  input  logic [REG_W-1:0]            ex_rd,
  input  logic                        ex_memread,
  output logic                        stall
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
    hzd_reg_match #(.REG_W(REG_W)) u_m (
      .a(id_src[g]), .b(ex_rd), .en(ex_memread), .hit(hit[g]));
  end

  always_comb stall = |hit;
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_memread,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_regwrite,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             pc_ifid_hold,
  output logic             idex_bubble
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0][REG_W-1:0] ex_src, id_src;
  opnd_src_e [N_SRC-1:0]       sel;
  logic                        stall;

  always_comb begin
    ex_src[0] = ex_rs1;
    ex_src[1] = ex_rs2;
    id_src[0] = id_rs1;
    id_src[1] = id_rs2;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_opnd
    hzd_fwd_select #(.REG_W(REG_W)) u_sel (
      .src(ex_src[g]), .mem_rd(mem_rd), .mem_regwrite(mem_regwrite),
      .mem_memread(mem_memread), .wb_rd(wb_rd), .wb_regwrite(wb_regwrite),
      .sel(sel[g]));
  end

  hzd_loaduse_detect #(.REG_W(REG_W), .N_SRC(N_SRC)) u_lu (
    .id_src(id_src), .ex_rd(ex_rd), .ex_memread(ex_memread), .stall(stall));

  always_comb begin
    fwd_a        = sel[0];
    fwd_b        = sel[1];
    pc_ifid_hold = stall;
    idex_bubble  = stall;
  end
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic [REG_W-1:0] ex_rs1,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_memread,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_regwrite,
  input logic             mem_memread,
  input logic [REG_W-1:0] wb_rd,
  input logic             wb_regwrite,
  input logic [1:0]       fwd_a,
  input logic             pc_ifid_hold
);
  always_comb begin
    if (fwd_a == 2'b10)
      assert_mem_src_valid_R5: assert (mem_regwrite && !mem_memread && mem_rd == ex_rs1 && mem_rd != '0);
    if (fwd_a == 2'b01)
      assert_wb_src_valid_R2: assert (wb_regwrite && wb_rd == ex_rs1 && wb_rd != '0);
    if (mem_regwrite && !mem_memread && mem_rd == ex_rs1 && mem_rd != '0)
      assert_mem_priority_R3: assert (fwd_a == 2'b10);
    if (!ex_memread)
      assert_no_alu_stall_R8: assert (!pc_ifid_hold);
    if (ex_rd == '0)
      assert_zero_no_stall_R4: assert (!pc_ifid_hold);
    if (pc_ifid_hold)
      assert_stall_cause_R7: assert (ex_rd == id_rs1 || ex_rd == id_rs2);
  end
endmodule

bind hzd_unit hzd_unit_chk #(.REG_W(REG_W)) u_chk (
  .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rd(ex_rd),
  .ex_memread(ex_memread), .mem_rd(mem_rd), .mem_regwrite(mem_regwrite),
  .mem_memread(mem_memread), .wb_rd(wb_rd), .wb_regwrite(wb_regwrite),
  .fwd_a(fwd_a), .pc_ifid_hold(pc_ifid_hold));

// File: tb/hzd_unit_test.sv
module hzd_unit_test;
  localparam int REG_W = 5;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [REG_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_memread, mem_regwrite, mem_memread, wb_regwrite;
  logic [1:0] fwd_a, fwd_b;
  logic pc_ifid_hold, idex_bubble;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hzd_unit #(.REG_W(REG_W)) uut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_memread(ex_memread), .mem_rd(mem_rd),
    .mem_regwrite(mem_regwrite), .mem_memread(mem_memread), .wb_rd(wb_rd),
    .wb_regwrite(wb_regwrite), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_ifid_hold(pc_ifid_hold), .idex_bubble(idex_bubble));

  function automatic logic [1:0] exp_sel(input logic [REG_W-1:0] s);
    if (mem_regwrite && !mem_memread && mem_rd != 0 && mem_rd == s) return 2'b10;
    if (wb_regwrite && wb_rd != 0 && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    return ex_memread && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [REG_W-1:0] i1, i2, e1, e2, erd,
                       input logic emr, input logic [REG_W-1:0] mrd,
                       input logic mrw, mmr, input logic [REG_W-1:0] wrd,
                       input logic wrw);
    @(posedge clk);
    id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2; ex_rd = erd;
    ex_memread = emr; mem_rd = mrd; mem_regwrite = mrw; mem_memread = mmr;
    wb_rd = wrd; wb_regwrite = wrw;
    @(negedge clk);
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " R10 fwd_a"}, 32'(fwd_a), 32'(exp_sel(ex_rs1)));
    chk({tag, " R10 fwd_b"}, 32'(fwd_b), 32'(exp_sel(ex_rs2)));
    chk({tag, " R7 hold"}, 32'(pc_ifid_hold), 32'(exp_stall()));
    chk({tag, " R7 bubble"}, 32'(idex_bubble), 32'(exp_stall()));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // reset state: all zero inputs
    apply(0,0,0,0,0,0,0,0,0,0,0);
    chk("reset R9 fwd_a", 32'(fwd_a), 0);
    chk("reset R8 hold", 32'(pc_ifid_hold), 0);
    // R1 ALU to ALU
    apply(0,0,5,6,0,0,5,1,0,0,0);
    chk("R1 alu-alu fwd_a", 32'(fwd_a), 2);
    chk("R9 fwd_b rf", 32'(fwd_b), 0);
    // R2 load two ahead
    apply(0,0,7,7,0,0,3,1,0,7,1);
    chk("R2 load two ahead", 32'(fwd_a), 1);
    chk("R10 fwd_b same", 32'(fwd_b), 1);
    // R3 priority
    apply(0,0,9,9,0,0,9,1,0,9,1);
    chk("R3 priority", 32'(fwd_a), 2);
    // R4 register 0
    apply(0,0,0,0,0,1,0,1,0,0,1);
    chk("R4 zero fwd", 32'(fwd_a), 0);
    chk("R4 zero stall", 32'(pc_ifid_hold), 0);
    // R5 no write enable
    apply(0,0,4,4,0,0,4,0,0,4,0);
    chk("R5 no regwrite", 32'(fwd_b), 0);
    // R6 load in MEM falls to WB
    apply(0,0,8,0,0,0,8,1,1,8,1);
    chk("R6 load in mem", 32'(fwd_a), 1);
    // R7 load-use stall on rs2
    apply(3,12,0,0,12,1,0,0,0,0,0);
    chk("R7 loaduse hold", 32'(pc_ifid_hold), 1);
    chk("R7 loaduse bubble", 32'(idex_bubble), 1);
    // R8 ALU producer no stall
    apply(12,12,0,0,12,0,0,0,0,0,0);
    chk("R8 alu no stall", 32'(pc_ifid_hold), 0);
    // R9 three behind: nothing in flight matches
    apply(0,0,31,30,0,0,2,1,0,3,1);
    chk("R9 three behind", 32'(fwd_a), 0);
    // top register numbers
    apply(31,0,31,31,31,1,31,1,0,30,1);
    chk_all("R1 top reg");
    // random
    for (int n = 0; n < 500; n++) begin
      apply(REG_W'($urandom_range(3)), REG_W'($urandom_range(3)),
            REG_W'($urandom_range(3)), REG_W'($urandom_range(3)),
            REG_W'($urandom_range(3)), 1'($urandom),
            REG_W'($urandom_range(3)), 1'($urandom), 1'($urandom),
            REG_W'($urandom_range(3)), 1'($urandom));
      chk_all("rand");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule